// File: doc/BRIEF.md
# Display Link Packet Assembler with Lane Striping

This block turns a command request into a byte-level packet for a display serial link and spreads those bytes over up to four parallel data lanes. A request carries a 6-bit data type, a 2-bit virtual channel, a long/short flag and a 16-bit word. For a short packet, the word holds the two payload bytes. For a long packet, it holds the payload length, and the payload bytes then stream in through a separate byte handshake. The block writes the identifier byte and computes the header ECC. For long packets it adds a 16-bit CRC footer. On request it follows the packet with an end-of-transmission packet.

The packet bytes go out one byte per lane per group. Byte j of the burst goes to lane j modulo the active lane count. The active lane count is taken when the request is accepted, so a change on that input during a packet has no effect. Each group appears on registered lane outputs together with a per-lane valid mask. When the burst ends, any lane that did not receive a byte in the last group gets no strobe.

Top module: `dsi_pkt_lane_tx`

## Requirements
- R1: While reset is high and in the first cycle after it, `lane_valid` is all zero and `req_ready` is high.
- R2: The first byte of every packet carries the virtual channel in bits [7:6] and the data type in bits [5:0] (for example, data type 0x05 on channel 0 gives 0x05).
- R3: A short packet is four bytes: the identifier, `req_word[7:0]`, `req_word[15:8]`, then the ECC byte with bits [7:6] zero.
- R4: ECC bit k is the XOR of the 24 header bits (byte 0 in bits 7:0, byte 1 in 15:8, byte 2 in 23:16) selected by mask k. The masks for k = 0 to 5 are 0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0 and 0xEFFC00.
- R5: In a long packet, header bytes 2 and 3 are the word count (low byte first). They are followed by exactly that many payload bytes, in the order they were accepted.
- R6: A long packet ends with a CRC over the payload, low byte first. The CRC is processed LSB first with polynomial x^16+x^12+x^5+1 (reflected 0x8408) and seed 0xFFFF, with no final inversion. A zero-length payload gives 0xFF 0xFF, and the ASCII string "123456789" gives 0x6F91.
- R7: When `req_eot` is set, the packet is followed by the four bytes 0x08 0x0F 0x0F 0x01.
- R8: `lane_sel` code 0 selects 1 lane, code 1 selects 2 lanes, code 2 selects 4 lanes, and code 3 selects 1 lane. Burst byte j is presented on lane j mod n, in group j div n.
- R9: The final group of a burst strobes only the lanes that received a byte. The valid mask is always a contiguous run starting at lane 0.
- R10: `lane_sel` is sampled only when a request is accepted. Changes while a packet is in progress do not alter its lane spreading.
- R11: While `pay_valid` is low, no payload byte is consumed. Stalls change only the timing of the output, not its byte sequence.
- R12: `req_ready` is low from the cycle after acceptance until the burst has been fully handed to the lane stage. Requests raised during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_vc | input | 2 | Virtual channel |
| req_dtype | input | 6 | Data type |
| req_long | input | 1 | 1: long packet, 0: short packet |
| req_word | input | 16 | Short: two payload bytes; long: word count |
| req_eot | input | 1 | Append end-of-transmission packet |
| lane_sel | input | 2 | Active lane count code |
| pay_data | input | 8 | Long payload byte |
| pay_valid | input | 1 | Payload byte present |
| pay_ready | output | 1 | Payload byte consumed this cycle if valid |
| lane_data | output | NUM_LANES*8 | Per-lane byte, lane 0 in bits [7:0] |
| lane_valid | output | NUM_LANES | Per-lane byte strobe |

## Verification
The bench drives short packets on different channels and data types. These show whether the identifier packing and every ECC mask are correct. It also drives long packets with lengths 0, 5, 7 and 9, which separate errors in the count field, in payload ordering and in the CRC footer. Runs at one, two and four lanes, and at code 3, pick out striping errors. Byte totals that are not multiples of the lane count test the partial final group. A packet sent with payload stalls while `lane_sel` changes under it, and a request pulsed while the block is busy, show whether the block ignores what it should.

// File: rtl/dsi_tx_pkg.sv
package dsi_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_CRC,
    ST_EOT
  } asm_state_t;

  localparam logic [5:0] EOT_DTYPE = 6'h08;
  localparam logic [7:0] EOT_FILL  = 8'h0F;

  // parity coverage of each ECC bit over the 24 header bits
  function automatic logic [23:0] ecc_mask(input int k);
    case (k)
      0:       ecc_mask = 24'hF12CB7;
      1:       ecc_mask = 24'hF2555B;
      2:       ecc_mask = 24'h749A6D;
      3:       ecc_mask = 24'hB8E38E;
      4:       ecc_mask = 24'hDF03F0;
      default: ecc_mask = 24'hEFFC00;
    endcase
  endfunction

  // one byte of the reflected CRC-16 (0x8408), LSB first
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsi_hdr_ecc.sv
module dsi_hdr_ecc
  import dsi_tx_pkg::*;
(
  input  logic [23:0] hdr,
  output logic [5:0]  ecc
);

  for (genvar k = 0; k < 6; k++) begin : g_par
    assign ecc[k] = ^(hdr & ecc_mask(k));
  end

endmodule

// File: rtl/dsi_crc16.sv
module dsi_crc16
  import dsi_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        seed,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || seed) crc <= 16'hFFFF;
    else if (en)     crc <= crc_step(crc, din);
  end

endmodule

// File: rtl/dsi_lane_stripe.sv
module dsi_lane_stripe #(
  parameter int NUM_LANES = 4,
  localparam int CW = $clog2(NUM_LANES + 1),
  localparam int IW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [7:0]             in_data,
  input  logic                   in_last,
  input  logic [CW-1:0]          lanes_n,
  output logic [NUM_LANES*8-1:0] out_data,
  output logic [NUM_LANES-1:0]   out_valid
);

  logic [IW-1:0]          idx;
  logic [7:0]             stage  [NUM_LANES];
  logic [NUM_LANES*8-1:0] merged;
  logic [NUM_LANES-1:0]   fill_mask;
  logic                   group_end;

  assign group_end = in_last || ((CW'(idx) + CW'(1)) >= lanes_n);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign merged[l*8 +: 8] = (IW'(l) == idx) ? in_data : stage[l];
    assign fill_mask[l]     = (IW'(l) <= idx);

    always_ff @(posedge clk) begin
      if (rst)                               stage[l] <= '0;
      else if (in_valid && IW'(l) == idx)    stage[l] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      out_data  <= '0;
      out_valid <= '0;
    end else begin
      out_valid <= '0;
      if (in_valid) begin
        if (group_end) begin
          out_data  <= merged;
          out_valid <= fill_mask;
          idx       <= '0;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end

  // R9
  contiguous_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid & (out_valid + 1'b1)) == '0);

  // R8
  lane_limit_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(out_valid) <= int'(lanes_n));

endmodule

// File: rtl/dsi_pkt_lane_tx.sv
module dsi_pkt_lane_tx
  import dsi_tx_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int WC_W      = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [1:0]             req_vc,
  input  logic [5:0]             req_dtype,
  input  logic                   req_long,
  input  logic [WC_W-1:0]        req_word,
  input  logic                   req_eot,
  input  logic [1:0]             lane_sel,
  input  logic [7:0]             pay_data,
  input  logic                   pay_valid,
  output logic                   pay_ready,
  output logic [NUM_LANES*8-1:0] lane_data,
  output logic [NUM_LANES-1:0]   lane_valid
);

  localparam int CW = $clog2(NUM_LANES + 1);
  localparam logic [23:0] EOT_HDR = {EOT_FILL, EOT_FILL, 2'b00, EOT_DTYPE};

  asm_state_t      state;
  logic [1:0]      sub;
  logic [23:0]     hdr_q;
  logic            long_q;
  logic            eot_q;
  logic [WC_W-1:0] remain;
  logic [CW-1:0]   lanes_q;
  logic [CW-1:0]   lanes_dec;
  logic [5:0]      hdr_ecc;
  logic [5:0]      eot_ecc;
  logic [15:0]     crc;
  logic            s_valid;
  logic [7:0]      s_data;
  logic            s_last;
  logic            accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign pay_ready = (state == ST_PAY);

  always_comb begin
    case (lane_sel)
      2'd1:    lanes_dec = CW'(2);
      2'd2:    lanes_dec = CW'(4);
      default: lanes_dec = CW'(1);
    endcase
    if (int'(lanes_dec) > NUM_LANES) lanes_dec = CW'(NUM_LANES);
  end

  dsi_hdr_ecc u_hdr_ecc (.hdr(hdr_q),   .ecc(hdr_ecc));
  dsi_hdr_ecc u_eot_ecc (.hdr(EOT_HDR), .ecc(eot_ecc));

  dsi_crc16 u_crc (
    .clk  (clk),
    .rst  (rst),
    .seed (accept),
    .en   (pay_ready && pay_valid),
    .din  (pay_data),
    .crc  (crc)
  );

  // byte source for the lane stage
  always_comb begin
    s_valid = 1'b0;
    s_data  = '0;
    s_last  = 1'b0;
    case (state)
      ST_HDR: begin
        s_valid = 1'b1;
        case (sub)
          2'd0:    s_data = hdr_q[7:0];
          2'd1:    s_data = hdr_q[15:8];
          2'd2:    s_data = hdr_q[23:16];
          default: s_data = {2'b00, hdr_ecc};
        endcase
        s_last = (sub == 2'd3) && !long_q && !eot_q;
      end
      ST_PAY: begin
        s_valid = pay_valid;
        s_data  = pay_data;
      end
      ST_CRC: begin
        s_valid = 1'b1;
        s_data  = sub[0] ? crc[15:8] : crc[7:0];
        s_last  = sub[0] && !eot_q;
      end
      ST_EOT: begin
        s_valid = 1'b1;
        case (sub)
          2'd0:    s_data = EOT_HDR[7:0];
          2'd1:    s_data = EOT_HDR[15:8];
          2'd2:    s_data = EOT_HDR[23:16];
          default: s_data = {2'b00, eot_ecc};
        endcase
        s_last = (sub == 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sub     <= '0;
      hdr_q   <= '0;
      long_q  <= 1'b0;
      eot_q   <= 1'b0;
      remain  <= '0;
      lanes_q <= CW'(1);
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          hdr_q   <= {req_word[15:8], req_word[7:0], req_vc, req_dtype};
          long_q  <= req_long;
          eot_q   <= req_eot;
          remain  <= req_word;
          lanes_q <= lanes_dec;
          sub     <= '0;
          state   <= ST_HDR;
        end
        ST_HDR: begin
          sub <= sub + 2'd1;
          if (sub == 2'd3) begin
            if (long_q)     state <= (remain == '0) ? ST_CRC : ST_PAY;
            else if (eot_q) state <= ST_EOT;
            else            state <= ST_IDLE;
          end
        end
        ST_PAY: if (pay_valid) begin
          remain <= remain - WC_W'(1);
          if (remain == WC_W'(1)) state <= ST_CRC;
        end
        ST_CRC: begin
          sub <= sub + 2'd1;
          if (sub[0]) begin
            sub   <= '0;
            state <= eot_q ? ST_EOT : ST_IDLE;
          end
        end
        ST_EOT: begin
          sub <= sub + 2'd1;
          if (sub == 2'd3) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  dsi_lane_stripe #(.NUM_LANES(NUM_LANES)) u_stripe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s_valid),
    .in_data   (s_data),
    .in_last   (s_last),
    .lanes_n   (lanes_q),
    .out_data  (lane_data),
    .out_valid (lane_valid)
  );

  // R12
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  // R12
  pay_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    pay_ready |-> !req_ready);

  // R10
  lanes_held_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(lanes_q));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pay_ready && !pay_valid) |=> (state == ST_PAY) && $stable(remain));

endmodule

// File: tb/test_dsi_pkt_lane_tx.sv
module test_dsi_pkt_lane_tx;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_vc = '0;
  logic [5:0]    req_dtype = '0;
  logic          req_long = 1'b0;
  logic [15:0]   req_word = '0;
  logic          req_eot = 1'b0;
  logic [1:0]    lane_sel = '0;
  logic [7:0]    pay_data = '0;
  logic          pay_valid = 1'b0;
  logic          pay_ready;
  logic [NL*8-1:0] lane_data;
  logic [NL-1:0]   lane_valid;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";

  logic [7:0]    pay_q [$];
  logic [7:0]    tmp_pay [$];
  logic [NL*8-1:0] exp_data [$];
  logic [NL-1:0]   exp_mask [$];
  logic          consumed = 1'b0;
  logic          stall_en = 1'b0;
  int            cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsi_pkt_lane_tx #(.NUM_LANES(NL)) i_dsi_pkt_lane_tx (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vc(req_vc), .req_dtype(req_dtype), .req_long(req_long),
    .req_word(req_word), .req_eot(req_eot), .lane_sel(lane_sel),
    .pay_data(pay_data), .pay_valid(pay_valid), .pay_ready(pay_ready),
    .lane_data(lane_data), .lane_valid(lane_valid)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ECC reference: each header bit contributes its own 6-bit column
  function automatic logic [5:0] ecc_ref(input logic [23:0] h);
    logic [5:0] col, e;
    e = '0;
    for (int i = 0; i < 24; i++) begin
      case (i)
        0: col = 6'h07;  1: col = 6'h0B;  2: col = 6'h0D;  3: col = 6'h0E;
        4: col = 6'h13;  5: col = 6'h15;  6: col = 6'h16;  7: col = 6'h19;
        8: col = 6'h1A;  9: col = 6'h1C; 10: col = 6'h23; 11: col = 6'h25;
       12: col = 6'h26; 13: col = 6'h29; 14: col = 6'h2A; 15: col = 6'h2C;
       16: col = 6'h31; 17: col = 6'h32; 18: col = 6'h34; 19: col = 6'h38;
       20: col = 6'h1F; 21: col = 6'h2F; 22: col = 6'h37; default: col = 6'h3B;
      endcase
      if (h[i]) e ^= col;
    end
    return e;
  endfunction

  function automatic logic [15:0] crc_ref(input logic [7:0] b [$]);
    logic [15:0] c = 16'hFFFF;
    foreach (b[k]) begin
      for (int i = 0; i < 8; i++) begin
        if (c[0] ^ b[k][i]) c = (c >> 1) ^ 16'h8408;
        else                c = c >> 1;
      end
    end
    return c;
  endfunction

  function automatic int lanes_of(input logic [1:0] s);
    return (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 1;
  endfunction

  // payload feeder
  always @(posedge clk) begin
    cyc      <= cyc + 1;
    consumed <= pay_valid && pay_ready;
  end

  always @(negedge clk) begin
    if (consumed && pay_q.size() > 0) void'(pay_q.pop_front());
    pay_valid = (pay_q.size() > 0) && !(stall_en && (cyc % 3 != 0));
    pay_data  = (pay_q.size() > 0) ? pay_q[0] : 8'h00;
  end

  // output comparator, every clock
  always @(negedge clk) begin
    if (!rst && lane_valid != '0) begin
      if (exp_mask.size() == 0) begin
        check(1'b0, {cur_tag, " unexpected group"}, lane_valid, 0);
      end else begin
        logic [NL*8-1:0] ed;
        logic [NL-1:0]   em;
        logic            ok;
        ed = exp_data.pop_front();
        em = exp_mask.pop_front();
        ok = (lane_valid == em);
        for (int l = 0; l < NL; l++)
          if (em[l] && lane_data[l*8 +: 8] != ed[l*8 +: 8]) ok = 1'b0;
        check(ok, cur_tag, {lane_valid, lane_data}, {em, ed});
      end
    end
  end

  task automatic send(input logic [1:0] vc, input logic [5:0] dt, input bit lng,
                      input logic [15:0] word, input bit eot, input logic [1:0] sel);
    logic [7:0] bytes [$];
    logic [23:0] h;
    int n;
    h = {word[15:8], word[7:0], vc, dt};
    bytes.push_back(h[7:0]);
    bytes.push_back(h[15:8]);
    bytes.push_back(h[23:16]);
    bytes.push_back({2'b00, ecc_ref(h)});
    if (lng) begin
      logic [15:0] c;
      c = crc_ref(tmp_pay);
      foreach (tmp_pay[k]) begin
        bytes.push_back(tmp_pay[k]);
        pay_q.push_back(tmp_pay[k]);
      end
      bytes.push_back(c[7:0]);
      bytes.push_back(c[15:8]);
    end
    if (eot) begin
      bytes.push_back(8'h08); bytes.push_back(8'h0F);
      bytes.push_back(8'h0F); bytes.push_back(8'h01);
    end
    n = lanes_of(sel);
    for (int g = 0; g * n < bytes.size(); g++) begin
      logic [NL*8-1:0] d = '0;
      logic [NL-1:0]   m = '0;
      for (int l = 0; l < n && g * n + l < bytes.size(); l++) begin
        d[l*8 +: 8] = bytes[g*n + l];
        m[l] = 1'b1;
      end
      exp_data.push_back(d);
      exp_mask.push_back(m);
    end
    tmp_pay.delete();
    while (!req_ready) @(negedge clk);
    req_vc = vc; req_dtype = dt; req_long = lng; req_word = word;
    req_eot = eot; lane_sel = sel; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R12 ready low after accept", req_ready, 0);
  endtask

  task automatic drain();
    while (exp_mask.size() > 0 || !req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lane_valid == '0 && req_ready, "R1 in reset", {lane_valid, req_ready}, 1);
    rst = 1'b0;
    @(negedge clk);
    check(lane_valid == '0 && req_ready, "R1 after reset", {lane_valid, req_ready}, 1);

    // bench anchors for the footer and trailer codes
    begin
      logic [7:0] s [$] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
      check(crc_ref(s) == 16'h6F91, "R6 crc anchor", crc_ref(s), 16'h6F91);
      check(ecc_ref(24'h0F0F08) == 6'h01, "R7 ecc anchor", ecc_ref(24'h0F0F08), 1);
    end

    cur_tag = "R2 R3 R4 short one lane";
    send(2'd0, 6'h05, 1'b0, 16'h0029, 1'b0, 2'd0);
    drain();

    cur_tag = "R2 R4 R7 R8 short two lanes with trailer";
    send(2'd2, 6'h15, 1'b0, 16'hA5C3, 1'b1, 2'd1);
    drain();

    cur_tag = "R5 R6 R7 R9 long nine bytes four lanes";
    tmp_pay = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send(2'd1, 6'h39, 1'b1, 16'd9, 1'b1, 2'd2);
    drain();

    cur_tag = "R5 R6 zero length two lanes";
    send(2'd3, 6'h29, 1'b1, 16'd0, 1'b0, 2'd1);
    drain();

    cur_tag = "R10 R11 stalled long with lane change";
    stall_en = 1'b1;
    tmp_pay = '{8'h00, 8'hFF, 8'h5A, 8'h81, 8'h7E, 8'h10, 8'hEE};
    send(2'd0, 6'h39, 1'b1, 16'd7, 1'b0, 2'd2);
    repeat (3) @(negedge clk);
    lane_sel = 2'd0;
    drain();
    stall_en = 1'b0;

    cur_tag = "R8 code three one lane";
    send(2'd1, 6'h23, 1'b0, 16'h1234, 1'b1, 2'd3);
    drain();

    cur_tag = "R9 R12 partial group and busy request";
    tmp_pay = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    send(2'd0, 6'h29, 1'b1, 16'd5, 1'b1, 2'd2);
    req_vc = 2'd3; req_dtype = 6'h3F; req_long = 1'b0; req_word = 16'hDEAD;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    drain();

    check(exp_mask.size() == 0, "R12 no extra packet", exp_mask.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule